// File: doc/BRIEF.md
# Query Report Memory Writer

This block watches a stream of method writes (an index plus a 32-bit argument) and keeps a small register set: the two halves of a 64-bit report address, a 32-bit sequence value and a 2-bit report mode. A write to the control method first stores the mode and then starts a report. Depending on the mode, the block either writes the sequence value as one word at the report address, or writes a 16-byte record made of a 64-bit counter (always 1) followed by a 64-bit timestamp taken from an internal free-running cycle counter. The other two mode values start nothing.

Writes leave through a valid/ready memory port as 32-bit beats, lowest address first. While a report is in flight the block is busy. A control write that arrives during that time is parked in a single pending slot and serviced once the current report is done. A later control write replaces whatever is parked.

Top module: `qrw_top`

## Requirements
- R1: After reset no memory beat is offered (`memValid` low) until a control write with an active mode arrives.
- R2: The method at index `BASE` holds bits 63:32 of the report address and the method at `BASE+1` holds bits 31:0. Report beats are addressed from that 64-bit value.
- R3: A write to the control method (`BASE+3`) stores its argument's bits 1:0 as the mode, and the report is decoded from that stored value. Argument bits 31:2 have no effect.
- R4: In mode 0, exactly one beat is written: the address is the report address and the data is the value last written to the sequence method (`BASE+2`) before the report starts.
- R5: In mode 2, exactly four beats are written, at report address +0, +4, +8 and +12 in that order. The data is 1, 0, timestamp bits 31:0 and timestamp bits 63:32.
- R6: The timestamp counts clock edges since reset release. A report started from an idle block captures the counter value one edge after the control write is taken, which equals the number of edges since reset before the write edge, plus one.
- R7: Mode 1 and mode 3 produce no memory beat.
- R8: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memData` hold their values.
- R9: A control write taken while a report is in flight is serviced after the current report completes. There is one pending slot, and the newest such write replaces an older one. Its sequence value is read when its report starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | A method write is present this cycle |
| cmdAddr | input | METHOD_W | Method index |
| cmdData | input | DATA_W | Method argument |
| memValid | output | 1 | A write beat is offered |
| memAddr | output | 2*DATA_W | Byte address of the offered beat |
| memData | output | DATA_W | Data of the offered beat |
| memReady | input | 1 | The memory side accepts the offered beat |

## Verification
Two things can land in the same cycle: a new control write and a report that is still draining beats, possibly on the very cycle its last beat is accepted. A sequence-register update can also coincide with a parked report. The bench throttles `memReady` to every other cycle so that a 16-byte record stays in flight. It issues back-to-back control writes, with one overwriting the parked slot, and then rewrites the sequence value. Then it checks that the captured beat list holds exactly the first record followed by one word carrying the newer sequence value.

// File: rtl/qrw_pkg.sv
package qrw_pkg;
  localparam logic [1:0] MODE_SEQ   = 2'd0;
  localparam logic [1:0] MODE_SYNC  = 2'd1;
  localparam logic [1:0] MODE_STAMP = 2'd2;
  localparam logic [1:0] MODE_NONE  = 2'd3;

  typedef struct packed {
    logic       snap;  // latch address, sequence and timestamp for a new report
    logic       wide;  // current report is the 16-byte record
    logic [1:0] beat;  // index of the beat on the port
  } qrw_strobe_t;
endpackage

// File: rtl/qrw_datapath.sv
module qrw_datapath
  import qrw_pkg::*;
#(
  parameter int                     METHOD_W = 12,
  parameter logic [METHOD_W-1:0]    BASE     = 12'h100,
  parameter int                     DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmdValid,
  input  logic [METHOD_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]     cmdData,
  input  qrw_strobe_t           strb,
  output logic                  trigPulse,
  output logic [1:0]            trigMode,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]     memData
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int TS_W   = 2 * DATA_W;
  localparam logic [METHOD_W-1:0] M_ADDR_HI = BASE;
  localparam logic [METHOD_W-1:0] M_ADDR_LO = BASE + METHOD_W'(1);
  localparam logic [METHOD_W-1:0] M_SEQ     = BASE + METHOD_W'(2);
  localparam logic [METHOD_W-1:0] M_CTRL    = BASE + METHOD_W'(3);
  localparam logic [TS_W-1:0]     REPORT_COUNT = TS_W'(1);

  logic [DATA_W-1:0] addrHi, addrLo, seqReg, snapSeq;
  logic [1:0]        modeReg;
  logic [TS_W-1:0]   timer, snapTs;
  logic [ADDR_W-1:0] snapAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrHi    <= '0;
      addrLo    <= '0;
      seqReg    <= '0;
      modeReg   <= MODE_SEQ;
      trigPulse <= 1'b0;
      timer     <= '0;
    end else begin
      timer     <= timer + TS_W'(1);
      trigPulse <= cmdValid && (cmdAddr == M_CTRL);
      if (cmdValid) begin
        case (cmdAddr)
          M_ADDR_HI: addrHi  <= cmdData;
          M_ADDR_LO: addrLo  <= cmdData;
          M_SEQ:     seqReg  <= cmdData;
          M_CTRL:    modeReg <= cmdData[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snapAddr <= '0;
      snapSeq  <= '0;
      snapTs   <= '0;
    end else if (strb.snap) begin
      snapAddr <= {addrHi, addrLo};
      snapSeq  <= seqReg;
      snapTs   <= timer;
    end
  end

  assign trigMode = modeReg;
  assign memAddr  = snapAddr + {{(ADDR_W-4){1'b0}}, strb.beat, 2'b00};

  always_comb begin
    if (!strb.wide) begin
      memData = snapSeq;
    end else begin
      case (strb.beat)
        2'd0:    memData = REPORT_COUNT[DATA_W-1:0];
        2'd1:    memData = REPORT_COUNT[TS_W-1:DATA_W];
        2'd2:    memData = snapTs[DATA_W-1:0];
        default: memData = snapTs[TS_W-1:DATA_W];
      endcase
    end
  end

  // R6: the timer only ever advances by one per edge
  a_r6_timer_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> timer == $past(timer) + TS_W'(1));
endmodule

// File: rtl/qrw_ctrl.sv
module qrw_ctrl
  import qrw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        trigPulse,
  input  logic [1:0]  trigMode,
  input  logic        memReady,
  output logic        memValid,
  output qrw_strobe_t strb
);
  logic       busy, wide, pendValid;
  logic [1:0] beat, pendMode, startMode;
  logic       startReq, lastBeat, startActive;

  assign startReq    = !busy && (pendValid || trigPulse);
  assign startMode   = pendValid ? pendMode : trigMode;
  assign startActive = (startMode == MODE_SEQ) || (startMode == MODE_STAMP);
  assign lastBeat    = wide ? (beat == 2'd3) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      wide      <= 1'b0;
      beat      <= 2'd0;
      pendValid <= 1'b0;
      pendMode  <= MODE_SEQ;
    end else if (!busy) begin
      if (startReq) begin
        busy <= startActive;
        wide <= (startMode == MODE_STAMP);
        beat <= 2'd0;
      end
      if (pendValid) begin
        pendValid <= trigPulse;
        pendMode  <= trigMode;
      end
    end else begin
      if (trigPulse) begin
        pendValid <= 1'b1;
        pendMode  <= trigMode;
      end
      if (memReady) begin
        if (lastBeat) busy <= 1'b0;
        else          beat <= beat + 2'd1;
      end
    end
  end

  assign memValid  = busy;
  assign strb.snap = startReq;
  assign strb.wide = wide;
  assign strb.beat = beat;

  // R7: modes 1 and 3 leave the port idle
  a_r7_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    trigPulse && !busy && !pendValid && trigMode[0] |=> !busy);
  // R9: a trigger during a report is parked
  a_r9_pend_kept: assert property (@(posedge clk) disable iff (rst)
    trigPulse && busy |=> pendValid);
  // R4: a sequence report never leaves beat 0
  a_r4_single_beat: assert property (@(posedge clk) disable iff (rst)
    busy && !wide |-> beat == 2'd0);
  // R5: record beats advance one at a time on acceptance
  a_r5_beat_step: assert property (@(posedge clk) disable iff (rst)
    busy && memReady && !lastBeat |=> busy && beat == $past(beat) + 2'd1);
endmodule

// File: rtl/qrw_top.sv
module qrw_top
  import qrw_pkg::*;
#(
  parameter int                  METHOD_W = 12,
  parameter logic [METHOD_W-1:0] BASE     = 12'h100,
  parameter int                  DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  input  logic [METHOD_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0]   cmdData,
  output logic                memValid,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memData,
  input  logic                memReady
);
  qrw_strobe_t strb;
  logic        trigPulse;
  logic [1:0]  trigMode;

  qrw_datapath #(.METHOD_W(METHOD_W), .BASE(BASE), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .strb(strb), .trigPulse(trigPulse), .trigMode(trigMode),
    .memAddr(memAddr), .memData(memData)
  );

  qrw_ctrl uCtrl (
    .clk(clk), .rst(rst), .trigPulse(trigPulse), .trigMode(trigMode),
    .memReady(memReady), .memValid(memValid), .strb(strb)
  );

  // R8: an offered beat is held until accepted
  a_r8_beat_hold: assert property (@(posedge clk) disable iff (rst)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));
  // R1: nothing is offered in the cycle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !memValid);
endmodule

// File: tb/tb_qrw_top.sv
`timescale 1ns/1ps
module tb_qrw_top;
  localparam int METHOD_W = 12;
  localparam logic [METHOD_W-1:0] BASE = 12'h100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [11:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic        memValid;
  logic [63:0] memAddr;
  logic [31:0] memData;
  logic        memReady;
  logic        throttle = 1'b0;

  int tbCnt = 0;
  int capCnt = 0;
  logic [63:0] capAddr [64];
  logic [31:0] capData [64];
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  qrw_top #(.METHOD_W(METHOD_W), .BASE(BASE), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memReady(memReady)
  );

  assign memReady = throttle ? tbCnt[0] : 1'b1;

  always @(posedge clk) begin
    if (rst) tbCnt <= 0;
    else     tbCnt <= tbCnt + 1;
    if (!rst && memValid && memReady && capCnt < 64) begin
      capAddr[capCnt] <= memAddr;
      capData[capCnt] <= memData;
      capCnt <= capCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendMethod(input logic [11:0] m, input logic [31:0] d, output int t);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = m; cmdData = d;
    t = tbCnt;
  endtask

  task automatic idleBus();
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic drain();
    int quiet = 0;
    for (int i = 0; i < 400 && quiet < 6; i++) begin
      @(negedge clk);
      if (memValid) quiet = 0; else quiet++;
    end
    check(quiet >= 6, "drain", 64'(quiet), 64'd6);
  endtask

  task automatic setup(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] seq);
    int t;
    sendMethod(BASE, hi, t);
    sendMethod(BASE + 12'd1, lo, t);
    sendMethod(BASE + 12'd2, seq, t);
    idleBus();
  endtask

  task automatic testReset();
    @(negedge clk);
    check(memValid == 1'b0, "R1 valid during reset", 64'(memValid), 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(memValid == 1'b0, "R1 valid after reset", 64'(memValid), 64'd0);
  endtask

  task automatic testSeqReport();
    int t, b;
    setup(32'h0000_0012, 32'h3456_0000, 32'hCAFE_0001);
    b = capCnt;
    sendMethod(BASE + 12'd3, 32'h0, t);
    idleBus();
    drain();
    check(capCnt - b == 1, "R4 beat count", 64'(capCnt - b), 64'd1);
    check(capAddr[b] == 64'h0000_0012_3456_0000, "R2 address halves", capAddr[b], 64'h0000_0012_3456_0000);
    check(capData[b] == 32'hCAFE_0001, "R4 sequence data", 64'(capData[b]), 64'hCAFE_0001);
  endtask

  task automatic testStampReport();
    int t, b;
    logic [63:0] ts;
    setup(32'h0000_000A, 32'h0000_0100, 32'h1);
    throttle = 1'b1;
    b = capCnt;
    sendMethod(BASE + 12'd3, 32'h2, t);
    idleBus();
    drain();
    throttle = 1'b0;
    ts = 64'(t + 1);
    check(capCnt - b == 4, "R5 beat count", 64'(capCnt - b), 64'd4);
    for (int i = 0; i < 4; i++)
      check(capAddr[b+i] == 64'h0000_000A_0000_0100 + 64'(4*i), "R5 beat address",
            capAddr[b+i], 64'h0000_000A_0000_0100 + 64'(4*i));
    check(capData[b] == 32'd1, "R5 counter low", 64'(capData[b]), 64'd1);
    check(capData[b+1] == 32'd0, "R5 counter high", 64'(capData[b+1]), 64'd0);
    check(capData[b+2] == ts[31:0], "R6 timestamp low", 64'(capData[b+2]), 64'(ts[31:0]));
    check(capData[b+3] == ts[63:32], "R6 timestamp high", 64'(capData[b+3]), 64'(ts[63:32]));
  endtask

  task automatic testNoWrite();
    int t, b;
    b = capCnt;
    sendMethod(BASE + 12'd3, 32'h1, t);
    idleBus();
    drain();
    check(capCnt == b, "R7 mode 1 silent", 64'(capCnt - b), 64'd0);
    sendMethod(BASE + 12'd3, 32'h3, t);
    idleBus();
    drain();
    check(capCnt == b, "R7 mode 3 silent", 64'(capCnt - b), 64'd0);
  endtask

  task automatic testUpperBits();
    int t, b;
    setup(32'h0, 32'h0000_2000, 32'h0BAD_F00D);
    b = capCnt;
    sendMethod(BASE + 12'd3, 32'hFFFF_FFFC, t);
    idleBus();
    drain();
    check(capCnt - b == 1, "R3 high bits ignored, mode 0", 64'(capCnt - b), 64'd1);
    check(capData[b] == 32'h0BAD_F00D, "R3 data", 64'(capData[b]), 64'h0BAD_F00D);
    b = capCnt;
    sendMethod(BASE + 12'd3, 32'h0000_0105, t);
    idleBus();
    drain();
    check(capCnt == b, "R3 high bits ignored, mode 1", 64'(capCnt - b), 64'd0);
  endtask

  task automatic testPending();
    int t, b;
    setup(32'h0, 32'h0000_4000, 32'h55);
    throttle = 1'b1;
    b = capCnt;
    sendMethod(BASE + 12'd3, 32'h2, t);
    sendMethod(BASE + 12'd3, 32'h2, t);
    sendMethod(BASE + 12'd3, 32'h0, t);
    sendMethod(BASE + 12'd2, 32'h77, t);
    idleBus();
    drain();
    throttle = 1'b0;
    check(capCnt - b == 5, "R9 record then newest pending", 64'(capCnt - b), 64'd5);
    check(capData[b] == 32'd1, "R9 first record first", 64'(capData[b]), 64'd1);
    check(capAddr[b+4] == 64'h4000, "R9 pending address", capAddr[b+4], 64'h4000);
    check(capData[b+4] == 32'h77, "R9 pending uses newer sequence", 64'(capData[b+4]), 64'h77);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testSeqReport();
    testStampReport();
    testNoWrite();
    testUpperBits();
    testPending();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule